// File: doc/BRIEF.md
# Processor Bus Burst Slave

This block is a synchronous slave on a 32-bit processor bus that numbers its bits big-endian style, with bus bit 0 as the most significant bit. The master opens a transfer with a one-clock start pulse. That pulse qualifies the local byte address, the direction, the transfer size and the burst flag. The slave answers each data beat with an active-low acknowledge that lasts one clock. Behind the bus side sits a small word store of 32-bit words. Each of its byte lanes is a separate array, so that each lane can be inferred as block RAM.

Single transfers move a byte, a half-word or a word. The lanes follow big-endian order: the lowest byte address maps to the most significant lane. A burst moves up to four whole words. The address steps by four and wraps inside an aligned 16-byte block. At the end of each acknowledged beat the slave samples the master's "more data" line. When the master drops that line, the burst ends early. After the final beat, or after an abort, the slave returns to idle and releases the read-data bus by deasserting its output enable.

The ports use descending vectors. Port bit 31 carries bus bit 0, and `bus_addr[17:0]` carries bus address bits 14 to 31, with bus bit 31 on port bit 0.

Top module: `pbus_burst_slave`

## Requirements
- R1: The word index is taken from byte-address port bits [MEM_AW+1:2]. Address bits above that range are ignored, so addresses that differ only there reach the same word.
- R2: With `bus_rd` high at start the slave returns the stored word on `bus_rdata`. With `bus_rd` low it stores `bus_wdata`. A read always returns the full 32-bit word.
- R3: Size code 01 selects one byte lane, chosen by address bits [1:0]: 0 selects port bits 31:24 and 3 selects 7:0. Size code 10 selects a half-word: address bit 1 equal to 0 selects bits 31:16, and 1 selects 15:0. Size codes 00 and 11 write all four lanes. A write leaves unselected lanes unchanged.
- R4: A start pulse is accepted only when the slave is idle. A start that arrives while a transfer is in progress neither writes nor produces an acknowledge.
- R5: `bus_ack_n` is high in the clock after the start edge. It is low for exactly one clock, the clock after the second rising edge, and high again afterwards.
- R6: `bus_burst_n` low at start makes a burst. Every beat of a burst is a full word whatever the size code. The word index within an aligned 16-byte block rises by one per beat and wraps from 3 to 0.
- R7: `bus_more` is sampled on the rising edge that ends each acknowledge cycle. In a burst, a high value brings the next acknowledge two clocks later, and a low value ends the transfer. In a single transfer `bus_more` has no effect.
- R8: `bus_rdata_oe` is high only in the acknowledge clock of a read beat. It is low between beats and after the transfer ends.
- R9: While `rst` is high and after its release, `bus_ack_n` is high and `bus_rdata_oe` is low until a transfer starts.
- R10: A burst ends after four beats even when `bus_more` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_start | input | 1 | One-clock pulse that opens a transfer |
| bus_addr | input | 18 | Local byte address (bus bits 14..31; bus bit 31 on port bit 0) |
| bus_rd | input | 1 | 1 = read from slave, 0 = write to slave |
| bus_size | input | 2 | 01 byte, 10 half-word, 00 or 11 word |
| bus_burst_n | input | 1 | Low = burst transfer |
| bus_more | input | 1 | Master requests another beat after the current one |
| bus_wdata | input | 32 | Write data (port bit 31 = bus bit 0) |
| bus_rdata | output | 32 | Read data, valid while the output enable is high |
| bus_rdata_oe | output | 1 | Drive enable for the read-data bus pads |
| bus_ack_n | output | 1 | Per-beat acknowledge, active low |

## Verification
The bench builds the slave with MEM_AW = 4, a 16-word store. This lets a write at byte address 0x4C land on the same word as 0x0C, which shows the aliasing of the upper address bits within a short run. MAX_BEATS stays at 4. This lets bursts that start mid-block wrap around, and a burst whose master never drops `bus_more` reaches the four-beat cap.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_BYTE = 2'b01;
  localparam logic [1:0] SZ_HALF = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_ACK    = 2'd2
  } pbs_state_t;
endpackage

// File: rtl/pbs_lane_decode.sv
module pbs_lane_decode
  import pbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size,
  input  logic [1:0]       lo_addr,
  input  logic             burst,
  output logic [LANES-1:0] lane_be
);
  // Lane LANES-1 (port bits 31:24) holds byte offset 0: big-endian order.
  localparam logic [LANES-1:0] TOP_LANE  = {1'b1, {(LANES-1){1'b0}}};
  localparam logic [LANES-1:0] HIGH_HALF = {2'b11, {(LANES-2){1'b0}}};
  localparam logic [LANES-1:0] LOW_HALF  = {{(LANES-2){1'b0}}, 2'b11};

  always_comb begin
    if (burst) begin
      lane_be = '1;
    end else begin
      case (size)
        SZ_BYTE: lane_be = TOP_LANE >> lo_addr;
        SZ_HALF: lane_be = lo_addr[1] ? LOW_HALF : HIGH_HALF;
        default: lane_be = '1;
      endcase
    end
  end

  p_byte_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
    (!burst && size == SZ_BYTE) |-> $countones(lane_be) == 1);
  p_half_two_lanes_r3: assert property (@(posedge clk) disable iff (rst)
    (!burst && size == SZ_HALF) |-> $countones(lane_be) == 2);
endmodule

// File: rtl/pbs_word_store.sv
module pbs_word_store
  import pbs_pkg::*;
#(
  parameter int MEM_AW = 6
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [MEM_AW-1:0] idx,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] arr [DEPTH];
    logic [7:0] q;

    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[g]) arr[idx] <= wdata[8*g +: 8];
        q <= arr[idx];
      end
    end

    assign rdata[8*g +: 8] = q;
  end
endmodule

// File: rtl/pbs_beat_ctrl.sv
module pbs_beat_ctrl
  import pbs_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int MEM_AW    = 6,
  parameter int MAX_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd,
  input  logic              burst_n,
  input  logic              more,
  input  logic [LANES-1:0]  lane_be,
  output logic              acc_en,
  output logic              acc_we,
  output logic [MEM_AW-1:0] acc_idx,
  output logic [LANES-1:0]  acc_be,
  output logic              ack_n,
  output logic              oe
);
  localparam int WRAP_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1;
  localparam int WRAP_HI = WRAP_W + 1;
  localparam logic [WRAP_W-1:0] LAST_BEAT = WRAP_W'(MAX_BEATS - 1);

  pbs_state_t        state;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] nxt;
  logic              rd_q;
  logic              burst_q;
  logic [LANES-1:0]  be_q;
  logic [WRAP_W-1:0] beat_cnt;

  // Next burst address: step one word inside the aligned block, keep the rest.
  always_comb begin
    nxt = cur;
    nxt[WRAP_HI:2] = cur[WRAP_HI:2] + WRAP_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur      <= '0;
      rd_q     <= 1'b0;
      burst_q  <= 1'b0;
      be_q     <= '0;
      beat_cnt <= '0;
      ack_n    <= 1'b1;
      oe       <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            cur      <= addr;
            rd_q     <= rd;
            burst_q  <= !burst_n;
            be_q     <= lane_be;
            beat_cnt <= '0;
            state    <= ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          ack_n <= 1'b0;
          oe    <= rd_q;
          state <= ST_ACK;
        end
        ST_ACK: begin
          ack_n <= 1'b1;
          oe    <= 1'b0;
          if (burst_q && more && beat_cnt != LAST_BEAT) begin
            beat_cnt <= beat_cnt + WRAP_W'(1);
            cur      <= nxt;
            state    <= ST_ACCESS;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign acc_en  = (state == ST_ACCESS);
  assign acc_we  = acc_en && !rd_q;
  assign acc_idx = cur[MEM_AW+1:2];
  assign acc_be  = be_q;

  p_ack_one_clock_r5: assert property (@(posedge clk) disable iff (rst)
    !ack_n |=> ack_n);
  p_oe_inside_ack_r8: assert property (@(posedge clk) disable iff (rst)
    oe |-> !ack_n);
  p_single_one_beat_r6: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !burst_q) |-> beat_cnt == '0);
  p_wrap_in_block_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACCESS && $past(state) == ST_ACK) |->
      (cur[ADDR_W-1:WRAP_HI+1] == $past(cur[ADDR_W-1:WRAP_HI+1]) &&
       cur[WRAP_HI:2] == $past(cur[WRAP_HI:2]) + WRAP_W'(1)));
  p_busy_ignores_start_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACCESS && start) |=> ($stable(rd_q) && $stable(cur)));
  p_burst_cap_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK && beat_cnt == LAST_BEAT) |=> state == ST_IDLE);
endmodule

// File: rtl/pbus_burst_slave.sv
module pbus_burst_slave
  import pbs_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int MEM_AW    = 6,
  parameter int MAX_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_start,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_size,
  input  logic              bus_burst_n,
  input  logic              bus_more,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rdata_oe,
  output logic              bus_ack_n
);
  logic [LANES-1:0]  lane_be;
  logic              acc_en;
  logic              acc_we;
  logic [MEM_AW-1:0] acc_idx;
  logic [LANES-1:0]  acc_be;

  pbs_lane_decode u_decode (
    .clk     (clk),
    .rst     (rst),
    .size    (bus_size),
    .lo_addr (bus_addr[1:0]),
    .burst   (!bus_burst_n),
    .lane_be (lane_be)
  );

  pbs_beat_ctrl #(
    .ADDR_W    (ADDR_W),
    .MEM_AW    (MEM_AW),
    .MAX_BEATS (MAX_BEATS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (bus_start),
    .addr    (bus_addr),
    .rd      (bus_rd),
    .burst_n (bus_burst_n),
    .more    (bus_more),
    .lane_be (lane_be),
    .acc_en  (acc_en),
    .acc_we  (acc_we),
    .acc_idx (acc_idx),
    .acc_be  (acc_be),
    .ack_n   (bus_ack_n),
    .oe      (bus_rdata_oe)
  );

  pbs_word_store #(
    .MEM_AW (MEM_AW)
  ) u_store (
    .clk   (clk),
    .en    (acc_en),
    .we    (acc_we),
    .idx   (acc_idx),
    .be    (acc_be),
    .wdata (bus_wdata),
    .rdata (bus_rdata)
  );
endmodule

// File: tb/pbus_burst_slave_test.sv
module pbus_burst_slave_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [17:0] addr = '0;
  logic        rd = 1'b0;
  logic [1:0]  size = 2'b00;
  logic        burst_n = 1'b1;
  logic        more = 1'b1;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        oe;
  logic        ack_n;

  int checks = 0;
  int errors = 0;
  logic [31:0] mdl [16];

  always #2 clk = ~clk;

  pbus_burst_slave #(.ADDR_W(18), .MEM_AW(4), .MAX_BEATS(4)) uut (
    .clk(clk), .rst(rst), .bus_start(start), .bus_addr(addr), .bus_rd(rd),
    .bus_size(size), .bus_burst_n(burst_n), .bus_more(more), .bus_wdata(wdata),
    .bus_rdata(rdata), .bus_rdata_oe(oe), .bus_ack_n(ack_n)
  );

  // {rd, size, byte address, write data}
  localparam int NV = 14;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 2'b00, 18'h00000, 32'h11223344},
    {1'b0, 2'b00, 18'h00004, 32'hAABBCCDD},
    {1'b0, 2'b01, 18'h00002, 32'h0000EE00},
    {1'b1, 2'b00, 18'h00000, 32'h0},
    {1'b0, 2'b10, 18'h00006, 32'h00005566},
    {1'b1, 2'b01, 18'h00005, 32'h0},
    {1'b0, 2'b11, 18'h00008, 32'h01020304},
    {1'b0, 2'b01, 18'h0000B, 32'h000000FF},
    {1'b0, 2'b00, 18'h0000C, 32'h00000000},
    {1'b0, 2'b10, 18'h0000C, 32'h77880000},
    {1'b1, 2'b10, 18'h0000E, 32'h0},
    {1'b1, 2'b00, 18'h00008, 32'h0},
    {1'b0, 2'b00, 18'h0004C, 32'hCAFEF00D},
    {1'b1, 2'b00, 18'h0000C, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Lane enables from R3: bit 3 = port bits 31:24 = byte offset 0.
  function automatic logic [3:0] lanes(input logic [1:0] sz, input logic [1:0] lo);
    case (sz)
      2'b01:   lanes = 4'b1000 >> lo;
      2'b10:   lanes = lo[1] ? 4'b0011 : 4'b1100;
      default: lanes = 4'b1111;
    endcase
  endfunction

  task automatic mwrite(input logic [3:0] idx, input logic [3:0] be, input logic [31:0] d);
    for (int i = 0; i < 4; i++)
      if (be[i]) mdl[idx][8*i +: 8] = d[8*i +: 8];
  endtask

  task automatic single(input logic r, input logic [1:0] sz, input logic [17:0] a,
                        input logic [31:0] d);
    @(negedge clk);
    start = 1'b1; rd = r; size = sz; addr = a; burst_n = 1'b1; more = 1'b1; wdata = d;
    @(negedge clk);
    start = 1'b0;
    chk("R5 ack high after start", {31'b0, ack_n}, 32'd1);
    @(negedge clk);
    chk("R5 ack low in beat", {31'b0, ack_n}, 32'd0);
    if (r) begin
      chk("R2 R3 read word", rdata, mdl[a[5:2]]);
      chk("R8 oe in read ack", {31'b0, oe}, 32'd1);
    end else begin
      chk("R8 oe low on write", {31'b0, oe}, 32'd0);
      mwrite(a[5:2], lanes(sz, a[1:0]), d);
    end
    @(negedge clk);
    chk("R5 ack released", {31'b0, ack_n}, 32'd1);
    chk("R8 oe released", {31'b0, oe}, 32'd0);
    @(negedge clk);
    chk("R7 no extra beat on single", {31'b0, ack_n}, 32'd1);
  endtask

  task automatic burst(input logic r, input logic [1:0] sz, input logic [17:0] a,
                       input int want);
    int beats = 0;
    logic [3:0] base = a[5:2];
    logic [3:0] idx;
    int exp_beats = (want < 4) ? want : 4;
    @(negedge clk);
    start = 1'b1; rd = r; size = sz; addr = a; burst_n = 1'b0; more = 1'b1;
    wdata = 32'hB0000000 | 32'(base);
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (!ack_n) begin
        idx = {base[3:2], base[1:0] + 2'(beats)};
        if (r) begin
          chk("R6 burst read word", rdata, mdl[idx]);
          chk("R8 oe in burst read", {31'b0, oe}, 32'd1);
        end else begin
          mdl[idx] = wdata;
        end
        beats++;
        more = (beats < want);
        wdata = 32'hB0000000 | 32'({base[3:2], base[1:0] + 2'(beats)}) | 32'(beats << 8);
      end else begin
        chk("R8 oe low outside ack", {31'b0, oe}, 32'd0);
      end
    end
    chk("R7 R10 beat count", 32'(beats), 32'(exp_beats));
    chk("R7 idle after burst", {31'b0, ack_n}, 32'd1);
    burst_n = 1'b1; more = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk("R9 ack high in reset", {31'b0, ack_n}, 32'd1);
    chk("R9 oe low in reset", {31'b0, oe}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 ack high after reset", {31'b0, ack_n}, 32'd1);

    // Table walk: single transfers of every size, partial writes, alias (R1).
    for (int v = 0; v < NV; v++)
      single(VEC[v][52], VEC[v][51:50], VEC[v][49:32], VEC[v][31:0]);

    // R1: 0x4C and 0x0C differ only above the word index bits.
    single(1'b1, 2'b00, 18'h0000C, 32'h0);
    chk("R1 alias word", mdl[3], 32'hCAFEF00D);

    // R4: start while busy is ignored.
    single(1'b0, 2'b00, 18'h00010, 32'h0);
    single(1'b0, 2'b00, 18'h00014, 32'h55555555);
    @(negedge clk);
    start = 1'b1; rd = 1'b0; size = 2'b00; addr = 18'h00010; burst_n = 1'b1;
    wdata = 32'h12345678;
    @(negedge clk);
    addr = 18'h00014;
    chk("R4 ack high before beat", {31'b0, ack_n}, 32'd1);
    @(negedge clk);
    start = 1'b0;
    chk("R4 first beat acked", {31'b0, ack_n}, 32'd0);
    mwrite(4'd4, 4'b1111, 32'h12345678);
    @(negedge clk);
    chk("R4 no second ack", {31'b0, ack_n}, 32'd1);
    @(negedge clk);
    chk("R4 no second ack later", {31'b0, ack_n}, 32'd1);
    single(1'b1, 2'b00, 18'h00014, 32'h0);
    chk("R4 busy start wrote nothing", mdl[5], 32'h55555555);
    single(1'b1, 2'b00, 18'h00010, 32'h0);

    // R6: wrapping write burst with byte size code, then read it back.
    burst(1'b0, 2'b01, 18'h00008, 4);
    burst(1'b1, 2'b00, 18'h00008, 4);
    // R10: master never drops the more-data line.
    burst(1'b1, 2'b10, 18'h00004, 6);
    // R7: early abort after two beats, single-beat burst.
    single(1'b0, 2'b00, 18'h0003C, 32'h0F0F0F0F);
    burst(1'b0, 2'b00, 18'h00034, 2);
    single(1'b1, 2'b00, 18'h00038, 32'h0);
    single(1'b1, 2'b00, 18'h0003C, 32'h0);
    chk("R7 word after abort untouched", mdl[15], 32'h0F0F0F0F);
    burst(1'b1, 2'b00, 18'h00034, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule